// File: doc/BRIEF.md
# Clock Fan-out Configuration Slave

This block is the two-wire management slave of a twelve-output differential clock fan-out device. It takes the raw clock and data lines of an SMBus 2.0 bus and oversamples them with the system clock. It answers at one of three device addresses and pulls the data line low through an open-drain enable. Behind the bus sits a small register file. That file holds the frequency-select, PLL/bypass and bandwidth controls, one enable bit per output, mirrors of the active-low output-enable pins, the identification bytes and the length of a block read.

The first byte after the address is the command, and it selects how the transfer proceeds. A zero command starts a block transfer at register 0. In a write, a byte count comes first and the data follows. In a read, the slave first returns the byte count held in register 7 and then the registers in rising order. A command whose top bit is set gives access to one register, at the offset held in its low seven bits. The block also combines each output's pin with its register enable to form the final per-output enable vector. The clock-synthesis logic consumes this vector together with the control fields.

Top module: `fanout_cfg_slave`

## Requirements
- R1: The slave acknowledges only the 7-bit address chosen by `addr_sel`: 00 selects 0x6E, 01 selects 0x6B, 10 or 11 selects 0x6A. Any other address gets no acknowledge, and the slave stays silent until the next start.
- R2: A command byte of 0x00 selects a block transfer starting at offset 0. A command with bit 7 set selects a single-register access at offset `cmd[6:0]`. Commands 0x01 to 0x7F are not acknowledged.
- R3: In a block write, the byte after the command is a count that the slave acknowledges and does not store. Each following data byte is acknowledged and written to offsets 0, 1, 2 and upward.
- R4: In a block read, the slave first sends register 7, then registers from offset 0 upward, each byte MSB first. When the master does not acknowledge a byte, the slave releases SDA and sends nothing more.
- R5: Register 0 maps `freq_sel` to bits [2:0], `pll_mode` to bit 6 (1 = PLL, 0 = bypass) and `low_bw` to bit 7. These bits load from `fs_pin`, `pll_mode_pin` and `low_bw_pin` during reset, and pin changes after reset have no effect. Bits [5:3] read 0. The stored fields drive the matching outputs.
- R6: Register 1 holds the enables of outputs 7..0 (bit i = output i), and register 2 bits [3:0] hold outputs 11..8. All enables reset to 1, and register 2 bits [7:4] read 0.
- R7: Register 3 reads `oe_n_pin[7:0]` and register 4 reads `{4'b0, oe_n_pin[11:8]}`. Writes to either register change nothing.
- R8: `out_en[i]` is 1 only when `oe_n_pin[i]` is 0 and the register enable of output i is 1.
- R9: Register 5 always reads 0x06 and register 6 always reads 0x0C. Writes to them are ignored.
- R10: Register 7 resets to 0x07, is writable, and reads back the written value.
- R11: Offsets above 7 read 0x00. Writes to them are acknowledged and discarded.
- R12: A start or stop seen at any point ends the transfer in progress. A byte cut short by one is not written.
- R13: `sda_oe` is 0 in reset and whenever no transfer is addressed to the slave. It is asserted only for acknowledge bits and for 0 data bits the slave sends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset; also loads the control pins |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| addr_sel | input | 2 | Three-level address select (00 low, 01 mid, 1x high) |
| fs_pin | input | 3 | Frequency-select pins, loaded at reset |
| pll_mode_pin | input | 1 | PLL (1) or bypass (0) pin, loaded at reset |
| low_bw_pin | input | 1 | Low-bandwidth pin (1 = low bandwidth), loaded at reset |
| oe_n_pin | input | 12 | Active-low per-output enable pins |
| out_en | output | 12 | Final per-output enable |
| freq_sel | output | 3 | Stored frequency select |
| pll_mode | output | 1 | Stored PLL/bypass choice |
| low_bw | output | 1 | Stored bandwidth choice |

## Verification
Assertions check on every cycle that the data line is released whenever no transfer is active. They also check that a stop always returns the controller to idle, that a master's not-acknowledge ends transmission, and that writes land only from the receive path. Further assertions check that register 7 and the upper enable nibble take exactly the written value, and that writes to read-only or unmapped offsets leave all stored state unchanged. The mapping of field bits, the reset capture of the pins, the three addresses, the command decode, the ordering of block reads and writes and the effect of an aborted byte can only be shown by the bench's bus transactions, which compare read-back bytes and output levels.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned OFF_W   = 7;
    localparam int unsigned NUM_OUT = 12;
    localparam int unsigned LAST_REG = 7;

    localparam logic [BYTE_W-1:0] VENDOR_REV    = 8'h06;
    localparam logic [BYTE_W-1:0] DEVICE_CODE   = 8'h0C;
    localparam logic [BYTE_W-1:0] COUNT_DEFAULT = 8'h07;

    typedef enum logic [2:0] {
        PH_IDLE, PH_RX, PH_RXACK, PH_TX, PH_TXACK
    } phase_e;

    typedef enum logic [1:0] {
        RB_ADDR, RB_CMD, RB_COUNT, RB_DATA
    } role_e;

    typedef struct packed {
        logic       low_bw;
        logic       pll_mode;
        logic [2:0] freq;
    } ctrl_t;

    function automatic logic [BYTE_W-1:0] pack_ctrl(ctrl_t c);
        return {c.low_bw, c.pll_mode, 3'b000, c.freq};
    endfunction

    function automatic logic [OFF_W-1:0] dev_addr_of(logic [1:0] sel);
        case (sel)
            2'b00:   return 7'h6E;
            2'b01:   return 7'h6B;
            default: return 7'h6A;
        endcase
    endfunction

    function automatic logic [OFF_W-1:0] ptr_next(logic [OFF_W-1:0] p);
        return (p == {OFF_W{1'b1}}) ? p : p + 1'b1;
    endfunction
endpackage

// File: rtl/fcs_line_filter.sv
module fcs_line_filter #(
    parameter int unsigned FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic clean
);
    localparam int unsigned CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync  <= 2'b11;
            clean <= 1'b1;
            cnt   <= '0;
        end else begin
            sync <= {sync[0], raw};
            if (sync[1] == clean) begin
                cnt <= '0;
            end else if (cnt == CW'(FILT_LEN - 1)) begin
                clean <= sync[1];
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/fcs_regfile.sv
module fcs_regfile
    import fcs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [2:0]           fs_pin,
    input  logic                 pll_mode_pin,
    input  logic                 low_bw_pin,
    input  logic [NUM_OUT-1:0]   oe_n_pin,
    input  logic                 wr_en,
    input  logic [OFF_W-1:0]     wr_off,
    input  logic [BYTE_W-1:0]    wr_data,
    input  logic [OFF_W-1:0]     rd_off,
    output logic [BYTE_W-1:0]    rd_data,
    output logic [BYTE_W-1:0]    count_val,
    output ctrl_t                ctrl,
    output logic [NUM_OUT-1:0]   out_en
);
    logic [NUM_OUT-1:0] en;
    logic [BYTE_W-1:0]  cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '{low_bw: low_bw_pin, pll_mode: pll_mode_pin, freq: fs_pin};
            en   <= '1;
            cnt  <= COUNT_DEFAULT;
        end else if (wr_en) begin
            case (wr_off)
                7'd0: ctrl <= '{low_bw: wr_data[7], pll_mode: wr_data[6], freq: wr_data[2:0]};
                7'd1: en[7:0]  <= wr_data;
                7'd2: en[11:8] <= wr_data[3:0];
                7'd7: cnt <= wr_data;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (rd_off)
            7'd0:    rd_data = pack_ctrl(ctrl);
            7'd1:    rd_data = en[7:0];
            7'd2:    rd_data = {4'b0000, en[11:8]};
            7'd3:    rd_data = oe_n_pin[7:0];
            7'd4:    rd_data = {4'b0000, oe_n_pin[11:8]};
            7'd5:    rd_data = VENDOR_REV;
            7'd6:    rd_data = DEVICE_CODE;
            7'd7:    rd_data = cnt;
            default: rd_data = '0;
        endcase
    end

    assign count_val = cnt;

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_gate
        assign out_en[g] = en[g] & ~oe_n_pin[g];
    end

    // R7, R9, R11: writes to read-only or unmapped offsets change no state
    assert_ro_write_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_off inside {7'd3, 7'd4, 7'd5, 7'd6} || wr_off > 7'd7))
        |=> ($stable(en) && $stable(ctrl) && $stable(cnt)));

    assert_count_write_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_off == 7'd7) |=> (cnt == $past(wr_data)));

    assert_upper_enable_write_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_off == 7'd2) |=> (en[11:8] == $past(wr_data[3:0]) && $stable(en[7:0])));
endmodule

// File: rtl/fcs_bus_engine.sv
module fcs_bus_engine
    import fcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scl,
    input  logic              sda,
    input  logic [OFF_W-1:0]  dev_addr,
    input  logic [BYTE_W-1:0] rd_data,
    input  logic [BYTE_W-1:0] count_val,
    output logic              sda_oe,
    output logic [OFF_W-1:0]  rd_off,
    output logic              wr_en,
    output logic [OFF_W-1:0]  wr_off,
    output logic [BYTE_W-1:0] wr_data
);
    phase_e            ph;
    role_e             role;
    logic              scl_q, sda_q;
    logic [BYTE_W-1:0] sh;
    logic [3:0]        bcnt;
    logic              is_rd, blk, tx_first;
    logic [OFF_W-1:0]  ptr;

    logic scl_rise, scl_fall, start_det, stop_det, use_count;
    logic [BYTE_W-1:0] tx_next;

    assign scl_rise  = scl & ~scl_q;
    assign scl_fall  = ~scl & scl_q;
    assign start_det = scl & scl_q & sda_q & ~sda;
    assign stop_det  = scl & scl_q & ~sda_q & sda;
    assign use_count = blk & tx_first;
    assign tx_next   = use_count ? count_val : rd_data;
    assign rd_off    = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph <= PH_IDLE; role <= RB_ADDR;
            scl_q <= 1'b1; sda_q <= 1'b1;
            sh <= '0; bcnt <= '0;
            is_rd <= 1'b0; blk <= 1'b0; tx_first <= 1'b0;
            ptr <= '0; sda_oe <= 1'b0;
            wr_en <= 1'b0; wr_off <= '0; wr_data <= '0;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
            wr_en <= 1'b0;
            if (start_det) begin
                ph <= PH_RX; role <= RB_ADDR; bcnt <= '0; sda_oe <= 1'b0;
            end else if (stop_det) begin
                ph <= PH_IDLE; sda_oe <= 1'b0;
            end else begin
                case (ph)
                    PH_RX: begin
                        if (scl_rise && bcnt != 4'd8) begin
                            sh   <= {sh[6:0], sda};
                            bcnt <= bcnt + 1'b1;
                        end else if (scl_fall && bcnt == 4'd8) begin
                            case (role)
                                RB_ADDR: begin
                                    if (sh[7:1] == dev_addr) begin
                                        is_rd <= sh[0]; tx_first <= 1'b1;
                                        role <= RB_CMD; sda_oe <= 1'b1; ph <= PH_RXACK;
                                    end else begin
                                        ph <= PH_IDLE;
                                    end
                                end
                                RB_CMD: begin
                                    if (sh == 8'h00) begin
                                        blk <= 1'b1; ptr <= '0; role <= RB_COUNT;
                                        sda_oe <= 1'b1; ph <= PH_RXACK;
                                    end else if (sh[7]) begin
                                        blk <= 1'b0; ptr <= sh[6:0]; role <= RB_DATA;
                                        sda_oe <= 1'b1; ph <= PH_RXACK;
                                    end else begin
                                        ph <= PH_IDLE;
                                    end
                                end
                                RB_COUNT: begin
                                    role <= RB_DATA; sda_oe <= 1'b1; ph <= PH_RXACK;
                                end
                                default: begin
                                    wr_en <= 1'b1; wr_off <= ptr; wr_data <= sh;
                                    ptr <= ptr_next(ptr);
                                    sda_oe <= 1'b1; ph <= PH_RXACK;
                                end
                            endcase
                        end
                    end
                    PH_RXACK, PH_TXACK: begin
                        if (ph == PH_TXACK && scl_rise && sda) begin
                            ph <= PH_IDLE;
                        end else if (scl_fall) begin
                            if (ph == PH_TXACK || is_rd) begin
                                if (!use_count) ptr <= ptr_next(ptr);
                                tx_first <= 1'b0;
                                sda_oe   <= ~tx_next[7];
                                sh       <= {tx_next[6:0], 1'b0};
                                bcnt     <= 4'd1;
                                ph       <= PH_TX;
                            end else begin
                                sda_oe <= 1'b0; bcnt <= '0; ph <= PH_RX;
                            end
                        end
                    end
                    PH_TX: begin
                        if (scl_fall) begin
                            if (bcnt == 4'd8) begin
                                sda_oe <= 1'b0; ph <= PH_TXACK;
                            end else begin
                                sda_oe <= ~sh[7];
                                sh     <= {sh[6:0], 1'b0};
                                bcnt   <= bcnt + 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assert_idle_release_R13: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_IDLE) |-> !sda_oe);

    assert_stop_abort_R12: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> (ph == PH_IDLE));

    assert_nack_release_R4: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_TXACK && scl_rise && sda) |=> (ph == PH_IDLE && !sda_oe));

    assert_write_from_rx_R3: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ($past(ph) == PH_RX && $past(role) == RB_DATA));
endmodule

// File: rtl/fanout_cfg_slave.sv
module fanout_cfg_slave
    import fcs_pkg::*;
#(
    parameter int unsigned FILT_LEN = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    input  logic [1:0]         addr_sel,
    input  logic [2:0]         fs_pin,
    input  logic               pll_mode_pin,
    input  logic               low_bw_pin,
    input  logic [NUM_OUT-1:0] oe_n_pin,
    output logic [NUM_OUT-1:0] out_en,
    output logic [2:0]         freq_sel,
    output logic               pll_mode,
    output logic               low_bw
);
    logic [1:0] raw_lines, clean_lines;
    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_filt
        fcs_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk   (clk),
            .rst   (rst),
            .raw   (raw_lines[g]),
            .clean (clean_lines[g])
        );
    end

    logic              wr_en;
    logic [OFF_W-1:0]  wr_off, rd_off;
    logic [BYTE_W-1:0] wr_data, rd_data, count_val;
    ctrl_t             ctrl;

    fcs_bus_engine u_engine (
        .clk       (clk),
        .rst       (rst),
        .scl       (clean_lines[1]),
        .sda       (clean_lines[0]),
        .dev_addr  (dev_addr_of(addr_sel)),
        .rd_data   (rd_data),
        .count_val (count_val),
        .sda_oe    (sda_oe),
        .rd_off    (rd_off),
        .wr_en     (wr_en),
        .wr_off    (wr_off),
        .wr_data   (wr_data)
    );

    fcs_regfile u_regs (
        .clk          (clk),
        .rst          (rst),
        .fs_pin       (fs_pin),
        .pll_mode_pin (pll_mode_pin),
        .low_bw_pin   (low_bw_pin),
        .oe_n_pin     (oe_n_pin),
        .wr_en        (wr_en),
        .wr_off       (wr_off),
        .wr_data      (wr_data),
        .rd_off       (rd_off),
        .rd_data      (rd_data),
        .count_val    (count_val),
        .ctrl         (ctrl),
        .out_en       (out_en)
    );

    assign freq_sel = ctrl.freq;
    assign pll_mode = ctrl.pll_mode;
    assign low_bw   = ctrl.low_bw;
endmodule

// File: tb/fanout_cfg_slave_tb.sv
module fanout_cfg_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 10;
    localparam logic [6:0] DEV = 7'h6E;
    // offset, data written, expected read-back
    localparam logic [23:0] VEC [0:7] = '{
        24'h00FFC7, 24'h013C3C, 24'h02FF0F, 24'h0300A5,
        24'h04FF00, 24'h050006, 24'h06FF0C, 24'h095500
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_drv = 1'b1, sda_drv = 1'b1;
    logic [1:0] addr_sel = 2'b00;
    logic [2:0] fs_pin = 3'b101;
    logic pll_mode_pin = 1'b1, low_bw_pin = 1'b0;
    logic [11:0] oe_n_pin = 12'h0A5;
    logic sda_oe, pll_mode, low_bw;
    logic [11:0] out_en;
    logic [2:0] freq_sel;
    logic sda_line;
    int total = 0, bad = 0;
    bit done = 1'b0;
    logic [7:0] rbuf [0:15];
    logic [7:0] wbuf [0:15];

    assign sda_line = sda_drv & ~sda_oe;
    always #(CLK_PERIOD/2) clk = ~clk;

    fanout_cfg_slave u_dut (
        .clk(clk), .rst(rst), .scl_i(scl_drv), .sda_i(sda_line), .sda_oe(sda_oe),
        .addr_sel(addr_sel), .fs_pin(fs_pin), .pll_mode_pin(pll_mode_pin),
        .low_bw_pin(low_bw_pin), .oe_n_pin(oe_n_pin), .out_en(out_en),
        .freq_sel(freq_sel), .pll_mode(pll_mode), .low_bw(low_bw)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; qwait(); scl_drv = 1'b1; qwait();
        sda_drv = 1'b0; qwait(); scl_drv = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; qwait(); scl_drv = 1'b1; qwait(); sda_drv = 1'b1; qwait();
    endtask

    task automatic send_bit(input logic b);
        sda_drv = b; qwait(); scl_drv = 1'b1; qwait(); qwait(); scl_drv = 1'b0; qwait();
    endtask

    task automatic get_bit(output logic b);
        sda_drv = 1'b1; qwait(); scl_drv = 1'b1; qwait(); b = sda_line; qwait();
        scl_drv = 1'b0; qwait();
    endtask

    task automatic wr_byte(input logic [7:0] d, output logic nack);
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        get_bit(nack);
    endtask

    task automatic rd_byte(output logic [7:0] d, input logic last);
        for (int i = 7; i >= 0; i--) get_bit(d[i]);
        send_bit(last);
    endtask

    task automatic byte_write(input logic [6:0] a, input logic [6:0] off,
                              input logic [7:0] d, output logic ok);
        logic n0, n1, n2;
        bus_start();
        wr_byte({a, 1'b0}, n0); wr_byte({1'b1, off}, n1); wr_byte(d, n2);
        bus_stop();
        ok = !n0 && !n1 && !n2;
    endtask

    task automatic byte_read(input logic [6:0] a, input logic [6:0] off, output logic [7:0] d);
        logic n0, n1, n2;
        bus_start();
        wr_byte({a, 1'b0}, n0); wr_byte({1'b1, off}, n1);
        bus_start();
        wr_byte({a, 1'b1}, n2); rd_byte(d, 1'b1);
        bus_stop();
    endtask

    task automatic block_read(input int n, output logic [7:0] cnt);
        logic n0, n1, n2;
        bus_start();
        wr_byte({DEV, 1'b0}, n0); wr_byte(8'h00, n1);
        bus_start();
        wr_byte({DEV, 1'b1}, n2);
        rd_byte(cnt, 1'b0);
        for (int i = 0; i < n; i++) rd_byte(rbuf[i], (i == n - 1));
        bus_stop();
    endtask

    task automatic block_write(input int n, output int nacks);
        logic nk;
        nacks = 0;
        bus_start();
        wr_byte({DEV, 1'b0}, nk); nacks += int'(nk);
        wr_byte(8'h00, nk);       nacks += int'(nk);
        wr_byte(8'(n), nk);       nacks += int'(nk);
        for (int i = 0; i < n; i++) begin
            wr_byte(wbuf[i], nk); nacks += int'(nk);
        end
        bus_stop();
    endtask

    function automatic string vtag(input int i);
        case (i)
            0: return "R5";
            1, 2: return "R6";
            3, 4: return "R7";
            5, 6: return "R9";
            default: return "R11";
        endcase
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic ok, nk;
        logic [7:0] d, cnt;
        int nacks;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        fs_pin = 3'b010; pll_mode_pin = 1'b0; low_bw_pin = 1'b1;
        repeat (3) @(negedge clk);
        // reset state
        check("R13 sda_oe idle", 32'(sda_oe), 32'h0);
        check("R8 out_en reset", 32'(out_en), 32'hF5A);
        check("R5 freq_sel captured", 32'(freq_sel), 32'h5);
        check("R5 pll_mode captured", 32'(pll_mode), 32'h1);
        check("R5 low_bw captured", 32'(low_bw), 32'h0);

        // R4 R10: default block read
        block_read(7, cnt);
        check("R10 default count", 32'(cnt), 32'h07);
        check("R4 blk byte0", 32'(rbuf[0]), 32'h45);
        check("R4 blk byte1", 32'(rbuf[1]), 32'hFF);
        check("R6 blk byte2", 32'(rbuf[2]), 32'h0F);
        check("R7 blk byte3", 32'(rbuf[3]), 32'hA5);
        check("R7 blk byte4", 32'(rbuf[4]), 32'h00);
        check("R9 blk byte5", 32'(rbuf[5]), 32'h06);
        check("R9 blk byte6", 32'(rbuf[6]), 32'h0C);
        check("R4 released after nack", 32'(sda_oe), 32'h0);

        // vector table: single-byte write then read back
        for (int i = 0; i < 8; i++) begin
            byte_write(DEV, VEC[i][22:16], VEC[i][15:8], ok);
            check({vtag(i), " write ack"}, 32'(ok), 32'h1);
            byte_read(DEV, VEC[i][22:16], d);
            check({vtag(i), " read back"}, 32'(d), 32'(VEC[i][7:0]));
        end
        check("R5 freq_sel written", 32'(freq_sel), 32'h7);
        check("R5 low_bw written", 32'(low_bw), 32'h1);
        check("R8 out_en mixed", 32'(out_en), 32'hF18);
        oe_n_pin = 12'h000; repeat (2) @(negedge clk);
        check("R8 out_en pins low", 32'(out_en), 32'hF3C);
        oe_n_pin = 12'hFFF; repeat (2) @(negedge clk);
        check("R8 out_en pins high", 32'(out_en), 32'h000);

        // R10: shorter block read
        byte_write(DEV, 7'd7, 8'h03, ok);
        block_read(3, cnt);
        check("R10 count written", 32'(cnt), 32'h03);
        check("R4 short blk byte0", 32'(rbuf[0]), 32'hC7);
        check("R4 short blk byte2", 32'(rbuf[2]), 32'h0F);

        // R3: block write
        oe_n_pin = 12'h000;
        wbuf[0] = 8'h86; wbuf[1] = 8'hFF; wbuf[2] = 8'h0A;
        block_write(3, nacks);
        check("R3 block write acks", 32'(nacks), 32'h0);
        check("R3 freq_sel", 32'(freq_sel), 32'h6);
        check("R3 pll_mode", 32'(pll_mode), 32'h0);
        repeat (2) @(negedge clk);
        check("R3 out_en", 32'(out_en), 32'hAFF);

        // R11: block write running past register 7
        oe_n_pin = 12'h3C0;
        wbuf[0] = 8'hC5; wbuf[1] = 8'hF0; wbuf[2] = 8'h03; wbuf[3] = 8'h11;
        wbuf[4] = 8'h22; wbuf[5] = 8'h33; wbuf[6] = 8'h44; wbuf[7] = 8'h09;
        wbuf[8] = 8'h77;
        block_write(9, nacks);
        check("R11 overrun acks", 32'(nacks), 32'h0);
        block_read(9, cnt);
        check("R10 count 9", 32'(cnt), 32'h09);
        check("R3 reg0", 32'(rbuf[0]), 32'hC5);
        check("R3 reg1", 32'(rbuf[1]), 32'hF0);
        check("R7 reg3 mirror", 32'(rbuf[3]), 32'hC0);
        check("R7 reg4 mirror", 32'(rbuf[4]), 32'h03);
        check("R9 reg5 kept", 32'(rbuf[5]), 32'h06);
        check("R11 offset8 zero", 32'(rbuf[8]), 32'h00);

        // R1: address selection
        byte_write(7'h6B, 7'd1, 8'h11, ok);
        check("R1 wrong addr nack", 32'(ok), 32'h0);
        addr_sel = 2'b01;
        byte_write(7'h6B, 7'd1, 8'h12, ok);
        check("R1 mid addr ack", 32'(ok), 32'h1);
        addr_sel = 2'b10;
        byte_read(7'h6A, 7'd1, d);
        check("R1 high addr read", 32'(d), 32'h12);
        byte_write(7'h6E, 7'd1, 8'h13, ok);
        check("R1 low addr refused", 32'(ok), 32'h0);
        addr_sel = 2'b00;

        // R2: reserved command
        bus_start();
        wr_byte({DEV, 1'b0}, nk);
        wr_byte(8'h05, nk);
        check("R2 bad command nack", 32'(nk), 32'h1);
        bus_stop();
        check("R13 released", 32'(sda_oe), 32'h0);

        // R12: stop in the middle of a data byte
        bus_start();
        wr_byte({DEV, 1'b0}, nk);
        wr_byte(8'h81, nk);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        bus_stop();
        byte_read(DEV, 7'd1, d);
        check("R12 partial byte dropped", 32'(d), 32'h12);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule